// File: doc/BRIEF.md
# Partition Membership Enforcement Checker

This block sits on the switch port that faces a single endpoint and screens every packet header arriving from that endpoint. The header carries a 16-bit partition key whose top bit is the sender's claimed full-membership flag and whose lower 15 bits name the partition, together with a flag saying whether the destination is a full member. The block searches a 16-entry membership table, loaded by a management agent through a write port, for the partition. If the partition is found, it applies an asymmetric rule. A full member may reach any member of the partition. A limited member may reach only full members.

Each header yields a registered pass or drop decision one cycle later. Every drop also bumps a saturating violation counter. The sender's effective membership is the AND of the claimed bit in the packet and the membership bit stored in the table, so an endpoint cannot promote itself by setting the bit. The management partition, identifier 0x7FFF, is one every endpoint belongs to. When the table has no entry for it, the endpoint is treated as a limited member of it.

Top module: `pm_enforce`

## Requirements
- R1: Synchronous reset clears the decision outputs, the violation counter and every table entry; after reset a header for a non-management partition is dropped.
- R2: A header presented with `hdr_valid` high in one cycle produces `dec_valid` high in the next cycle and in no other; `dec_pass` is low whenever `dec_valid` is low.
- R3: A header whose partition (key bits 14:0) matches no valid table entry, and is not 0x7FFF, is dropped.
- R4: When the packet's key bit 15 and the matching entry's bit 15 are both 1, the header passes whatever the destination flag.
- R5: When the effective membership is limited, the header passes only if `hdr_dst_full` is 1.
- R6: A packet with key bit 15 set that matches an entry whose bit 15 is 0 is treated as limited.
- R7: Partition 0x7FFF with no table entry is treated as a limited member: it passes only towards a full destination. A table entry for 0x7FFF overrides this default.
- R8: Each drop decision raises `viol_count` by exactly one in the cycle `dec_valid` is high, and a pass or an idle cycle leaves it unchanged.
- R9: `viol_count` saturates at 0xFFFF.
- R10: A table write and a header in the same cycle: the header is judged against the contents from before the write, and the write takes effect for the next header.
- R11: Writing an entry with `cfg_en` low removes it from the search. When several valid entries hold the same partition, the lowest index decides the membership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 4 | Table entry index to write |
| cfg_en | input | 1 | Valid flag for the written entry |
| cfg_key | input | 16 | Entry key: bit 15 full flag, bits 14:0 partition |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_src_key | input | 16 | Packet key: bit 15 claimed full flag, bits 14:0 partition |
| hdr_dst_full | input | 1 | Destination is a full member |
| dec_valid | output | 1 | Decision present |
| dec_pass | output | 1 | 1 forward, 0 drop |
| viol_count | output | 16 | Saturating count of drops |

## Verification
A table write and a header lookup can land in the same cycle. The bench provokes this by writing an entry for a partition that was absent while a header for that partition is presented. It expects a drop judged on the old table, then a pass for an identical header one cycle later. Counter saturation and a further drop also coincide: the bench streams about 70,000 back-to-back dropped headers and expects the counter to stop at 0xFFFF rather than wrap.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int KEY_W_DEF   = 16;
  localparam int ENTRIES_DEF = 16;
  localparam int CNT_W_DEF   = 16;

  // Where the membership of a looked-up partition came from
  typedef enum logic [1:0] {
    HIT_NONE  = 2'd0,
    HIT_TABLE = 2'd1,
    HIT_MGMT  = 2'd2
  } hit_src_e;
endpackage

// File: rtl/pm_table.sv
module pm_table #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [IDX_W-1:0]                idx,
  input  logic                            en,
  input  logic [KEY_W-1:0]                key,
  output logic [ENTRIES-1:0]              ent_vld,
  output logic [ENTRIES-1:0][KEY_W-1:0]   ent_key
);
  // Held in flops: every entry is compared in parallel each cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld <= '0;
    end else if (we) begin
      ent_vld[idx] <= en;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      ent_key[idx] <= key;
    end
  end
endmodule

// File: rtl/pm_match.sv
module pm_match
  import pm_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 16,
  parameter logic [KEY_W-2:0] MGMT_ID = '1,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]              ent_vld,
  input  logic [ENTRIES-1:0][KEY_W-1:0]   ent_key,
  input  logic [KEY_W-2:0]                pkt_id,
  output hit_src_e                        hit,
  output logic                            ent_full
);
  logic [ENTRIES-1:0] cmp;
  logic [IDX_W-1:0]   sel;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign cmp[g] = ent_vld[g] && (ent_key[g][KEY_W-2:0] == pkt_id);
    end
  endgenerate

  // Lowest matching index wins
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (cmp[i]) sel = i[IDX_W-1:0];
    end
  end

  always_comb begin
    if (|cmp) begin
      hit      = HIT_TABLE;
      ent_full = ent_key[sel][KEY_W-1];
    end else if (pkt_id == MGMT_ID) begin
      hit      = HIT_MGMT;
      ent_full = 1'b0;
    end else begin
      hit      = HIT_NONE;
      ent_full = 1'b0;
    end
  end
endmodule

// File: rtl/pm_decide.sv
module pm_decide
  import pm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hdr_valid,
  input  logic             pkt_full,
  input  logic             dst_full,
  input  hit_src_e         hit,
  input  logic             ent_full,
  output logic             dec_valid,
  output logic             dec_pass,
  output logic [CNT_W-1:0] viol_count
);
  logic allow;

  assign allow = (hit != HIT_NONE) && ((pkt_full && ent_full) || dst_full);

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_pass   <= 1'b0;
      viol_count <= '0;
    end else begin
      dec_valid <= hdr_valid;
      dec_pass  <= hdr_valid && allow;
      if (hdr_valid && !allow && (viol_count != {CNT_W{1'b1}})) begin
        viol_count <= viol_count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pm_enforce.sv
module pm_enforce
  import pm_pkg::*;
#(
  parameter int ENTRIES = ENTRIES_DEF,
  parameter int KEY_W   = KEY_W_DEF,
  parameter int CNT_W   = CNT_W_DEF,
  parameter logic [KEY_W-2:0] MGMT_ID = '1,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_en,
  input  logic [KEY_W-1:0] cfg_key,
  input  logic             hdr_valid,
  input  logic [KEY_W-1:0] hdr_src_key,
  input  logic             hdr_dst_full,
  output logic             dec_valid,
  output logic             dec_pass,
  output logic [CNT_W-1:0] viol_count
);
  logic [ENTRIES-1:0]            ent_vld;
  logic [ENTRIES-1:0][KEY_W-1:0] ent_key;
  hit_src_e                      hit;
  logic                          ent_full;

  pm_table #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_table (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx), .en(cfg_en),
    .key(cfg_key), .ent_vld(ent_vld), .ent_key(ent_key)
  );

  pm_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .MGMT_ID(MGMT_ID)) u_match (
    .ent_vld(ent_vld), .ent_key(ent_key), .pkt_id(hdr_src_key[KEY_W-2:0]),
    .hit(hit), .ent_full(ent_full)
  );

  pm_decide #(.CNT_W(CNT_W)) u_decide (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid),
    .pkt_full(hdr_src_key[KEY_W-1]), .dst_full(hdr_dst_full),
    .hit(hit), .ent_full(ent_full),
    .dec_valid(dec_valid), .dec_pass(dec_pass), .viol_count(viol_count)
  );
endmodule

// File: rtl/pm_enforce_chk.sv
module pm_enforce_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             hdr_valid,
  input logic             dec_valid,
  input logic             dec_pass,
  input logic [CNT_W-1:0] viol_count
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (viol_count == '0 && !dec_valid && !dec_pass));

  // R2
  dec_follow_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |=> dec_valid);

  // R2
  dec_cause_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(hdr_valid));

  // R2
  pass_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> !dec_pass);

  // R8
  drop_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_pass && $past(viol_count) != {CNT_W{1'b1}})
      |-> viol_count == $past(viol_count) + 1'b1);

  // R8
  no_drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(dec_valid && !dec_pass) |-> $stable(viol_count));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(viol_count) == {CNT_W{1'b1}}) |-> viol_count == {CNT_W{1'b1}});
endmodule

bind pm_enforce pm_enforce_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .dec_valid(dec_valid),
  .dec_pass(dec_pass), .viol_count(viol_count)
);

// File: tb/pm_enforce_tb.sv
`timescale 1ns/1ps
module pm_enforce_tb;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic        cfg_en = 1'b0;
  logic [15:0] cfg_key = '0;
  logic        hdr_valid = 1'b0;
  logic [15:0] hdr_src_key = '0;
  logic        hdr_dst_full = 1'b0;
  logic        dec_valid, dec_pass;
  logic [15:0] viol_count;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int cnt_exp = 0;

  // Bench model of the table
  bit          m_vld [16];
  logic [15:0] m_key [16];

  always #(CLK_NS/2) clk = ~clk;

  pm_enforce u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_key(cfg_key), .hdr_valid(hdr_valid), .hdr_src_key(hdr_src_key),
    .hdr_dst_full(hdr_dst_full), .dec_valid(dec_valid), .dec_pass(dec_pass),
    .viol_count(viol_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_pass(input logic [15:0] key, input bit dst);
    for (int i = 0; i < 16; i++) begin
      if (m_vld[i] && m_key[i][14:0] == key[14:0])
        return (key[15] && m_key[i][15]) || dst;
    end
    if (key[14:0] == 15'h7FFF) return dst;
    return 1'b0;
  endfunction

  task automatic wr(input int idx, input bit en, input logic [15:0] key);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx[3:0]; cfg_en = en; cfg_key = key;
    @(negedge clk);
    cfg_we = 1'b0;
    m_vld[idx] = en; m_key[idx] = key;
  endtask

  task automatic send(input logic [15:0] key, input bit dst, input string req);
    bit e;
    @(negedge clk);
    hdr_valid = 1'b1; hdr_src_key = key; hdr_dst_full = dst;
    e = exp_pass(key, dst);
    if (!e && cnt_exp < 16'hFFFF) cnt_exp++;
    @(negedge clk);
    hdr_valid = 1'b0;
    check(dec_valid == 1'b1, {req, " dec_valid"}, dec_valid, 1);
    check(dec_pass == e, {req, " dec_pass"}, dec_pass, e);
    check(viol_count == cnt_exp[15:0], {req, " R8 count"}, viol_count, cnt_exp);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_vld[i] = 1'b0; m_key[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(dec_valid == 1'b0, "R1 dec_valid", dec_valid, 0);
    check(dec_pass == 1'b0, "R1 dec_pass", dec_pass, 0);
    check(viol_count == 16'h0, "R1 count", viol_count, 0);
    send(16'h8123, 1'b1, "R1 empty table");
    // R2 no decision when idle
    @(negedge clk);
    check(dec_valid == 1'b0, "R2 idle", dec_valid, 0);

    // Fill all entries, odd indices full
    for (int i = 0; i < 16; i++)
      wr(i, 1'b1, {i[0], 15'(i * 16'h0111 + 5)});
    // Sweep every entry under every claim/destination combination (R4 R5 R6)
    for (int i = 0; i < 16; i++)
      for (int c = 0; c < 4; c++)
        send({c[0], 15'(i * 16'h0111 + 5)}, c[1], "R4/R5/R6 sweep");
    // R3 misses
    send(16'h8004, 1'b1, "R3 miss");
    send(16'h0ABC, 1'b0, "R3 miss");

    // R11 removal
    wr(6, 1'b0, 16'h0000);
    send({1'b1, 15'(6 * 16'h0111 + 5)}, 1'b1, "R11 removed entry");
    // R11 duplicate: index 2 limited, index 9 full, same partition
    wr(2, 1'b1, 16'h0444);
    wr(9, 1'b1, 16'h8444);
    send(16'h8444, 1'b0, "R11 lowest index");

    // R7 management default and override
    send(16'hFFFF, 1'b0, "R7 mgmt limited");
    send(16'h7FFF, 1'b1, "R7 mgmt to full");
    wr(12, 1'b1, 16'hFFFF);
    send(16'hFFFF, 1'b0, "R7 mgmt table entry");

    // R10 write and lookup in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'd6; cfg_en = 1'b1; cfg_key = 16'h8321;
    hdr_valid = 1'b1; hdr_src_key = 16'h8321; hdr_dst_full = 1'b0;
    cnt_exp++;
    @(negedge clk);
    cfg_we = 1'b0; hdr_valid = 1'b0;
    m_vld[6] = 1'b1; m_key[6] = 16'h8321;
    check(dec_valid == 1'b1 && dec_pass == 1'b0, "R10 old contents", dec_pass, 0);
    check(viol_count == cnt_exp[15:0], "R10 count", viol_count, cnt_exp);
    send(16'h8321, 1'b0, "R10 new contents");

    // R9 saturation with back-to-back drops
    @(negedge clk);
    hdr_valid = 1'b1; hdr_src_key = 16'h0555; hdr_dst_full = 1'b0;
    repeat (70000) @(negedge clk);
    hdr_valid = 1'b0;
    cnt_exp = 16'hFFFF;
    check(viol_count == 16'hFFFF, "R9 saturate", viol_count, 16'hFFFF);
    send(16'h0555, 1'b0, "R9 stays");
    send(16'h8321, 1'b0, "R9 pass after saturation");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule